// File: doc/BRIEF.md
# Chained Driver Command Decoder

This block sits inside one driver of a chain of identical drivers that share a single command bus. Every driver sees every 16-bit command. The block decides whether its own driver accepts a write and whether it drives read data onto the shared return line. Each driver knows its assigned position in the chain as an 8-bit address. All drivers also hold a copy of a shared pointer that names the driver targeted by "single driver" commands. The pointer lives in this block and can step forward after a command.

A command word is laid out as follows. Bit 15 selects read (1) or write (0). Bit 14 requests a pointer step. Bit 13 selects all drivers (1) or the pointed-to driver only (0). Bit 12 is reserved. Bits 11..8 hold the register number and bits 7..0 hold the data. The lower register half (0x0-0x7) obeys bits 13 and 14. The upper half (0x8-0xF) ignores both, writes go to every driver, and only the driver at address 0 answers reads. Register 0x0 reads back the driver's own address and cannot be written. Register 0x8 is the pointer itself.

A state machine runs each accepted command in two cycles. In ST_IDLE a valid command is latched. The transition IDLE→WRITE is taken for a write and IDLE→READ for a read. ST_WRITE raises the register-file strobe, and ST_READ drives the read port. Both states return unconditionally to ST_IDLE (WRITE→IDLE, READ→IDLE). Any pointer step or load takes effect on that return edge.

Top module: `chain_cmd_decoder`

## Requirements
- R1: After reset the state is idle, the pointer is 0x00, wr_strobe is all zero and rd_en is low.
- R2: A command is latched only when cmd_valid is high in ST_IDLE. Its outputs appear during the single following cycle. cmd_valid while a command executes is ignored.
- R3: A write to register 0x1-0x7 with bit 13 = 0 raises its strobe only when the pointer equals own_addr.
- R4: A write to register 0x1-0x7 with bit 13 = 1 raises its strobe on every driver.
- R5: A write to register 0x9-0xF raises its strobe on every driver. Bits 13 and 14 are ignored and the pointer is left unchanged.
- R6: A write to register 0x8 loads the pointer with bits 7..0 on every driver and raises no strobe.
- R7: For register 0x0-0x7, a bit 14 = 1 read or write steps the pointer by one (0xFF wraps to 0x00) after the command. Selection uses the value before the step.
- R8: A read of register 0x0-0x7 sets rd_en only when the pointer equals own_addr. Bit 13 is ignored.
- R9: A read of register 0x8-0xF sets rd_en only when own_addr is 0x00.
- R10: Read data is own_addr for register 0x0, the pointer for 0x8, and rf_rdata otherwise. rd_data is 0x00 whenever rd_en is low.
- R11: A write to register 0x0 raises no strobe.
- R12: wr_strobe is at most one-hot, with bit n standing for register n. wr_data carries command bits 7..0.
- R13: Command bit 12 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Parsed command word |
| own_addr | input | 8 | This driver's assigned chain address |
| rf_rdata | input | 8 | Register-file read data for the latched register number |
| wr_strobe | output | 16 | One-hot write strobe, bit n for register n |
| wr_data | output | 8 | Write data |
| rd_en | output | 1 | This driver owns the shared read line |
| rd_data | output | 8 | Read data, zero when not enabled |

## Verification
Target selection and the pointer step can fall in the same command. A local command with bit 14 set must be judged against the pointer as it stood before the step. The bench provokes this by placing the pointer at 0xFE with own_addr 0xFE and issuing two stepping writes back to back. Only the first may strobe, and a later pointer read must show the wrap to 0x00. A stepping read is also checked to assert rd_en while it advances the pointer.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

    localparam int CMD_W    = 16;
    localparam int DATA_W   = 8;
    localparam int REG_AW   = 4;
    localparam int REG_N    = 1 << REG_AW;
    localparam logic [REG_AW-1:0] REG_SELF_ADDR = 4'h0;
    localparam logic [REG_AW-1:0] REG_POINTER   = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } dec_state_t;

    typedef struct packed {
        logic              is_read;
        logic              step;
        logic              to_all;
        logic              rsvd;
        logic [REG_AW-1:0] reg_a;
        logic [DATA_W-1:0] data;
    } cmd_t;

endpackage

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import chain_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  cmd_t       cmd_in,
    output dec_state_t state_q,
    output cmd_t       cmd_q
);

    dec_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = cmd_in.is_read ? ST_READ : ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            ST_READ:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid)
                cmd_q <= cmd_in;
        end
    end

endmodule

// File: rtl/target_select.sv
module target_select
    import chain_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  dec_state_t        state_q,
    input  cmd_t              cmd_q,
    input  logic [ADDR_W-1:0] ptr_q,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic              step_req,
    output logic              ptr_load
);

    logic lower_half;
    logic ptr_match;
    logic is_master;
    logic unused_fields;

    assign lower_half    = ~cmd_q.reg_a[REG_AW-1];
    assign ptr_match     = (ptr_q == own_addr);
    assign is_master     = (own_addr == '0);
    assign unused_fields = ^{cmd_q.rsvd, cmd_q.data, cmd_q.is_read};

    always_comb begin
        wr_hit   = 1'b0;
        rd_hit   = 1'b0;
        step_req = 1'b0;
        ptr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                if (lower_half) begin
                    wr_hit   = (cmd_q.to_all || ptr_match) && (cmd_q.reg_a != REG_SELF_ADDR);
                    step_req = cmd_q.step;
                end else if (cmd_q.reg_a == REG_POINTER) begin
                    ptr_load = 1'b1;
                end else begin
                    wr_hit = 1'b1;
                end
            end
            ST_READ: begin
                if (lower_half) begin
                    rd_hit   = ptr_match;
                    step_req = cmd_q.step;
                end else begin
                    rd_hit = is_master;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/index_pointer.sv
module index_pointer #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= load_val;
        else if (step)
            ptr_q <= ptr_q + 1'b1;
    end

endmodule

// File: rtl/chain_cmd_decoder.sv
module chain_cmd_decoder
    import chain_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [REG_N-1:0]  wr_strobe,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    dec_state_t        state_q;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              wr_hit;
    logic              rd_hit;
    logic              step_req;
    logic              ptr_load;

    cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_t'(cmd_word)),
        .state_q   (state_q),
        .cmd_q     (cmd_q)
    );

    target_select #(.ADDR_W(ADDR_W)) u_sel (
        .state_q  (state_q),
        .cmd_q    (cmd_q),
        .ptr_q    (ptr_q),
        .own_addr (own_addr),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .step_req (step_req),
        .ptr_load (ptr_load)
    );

    index_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ADDR_W'(cmd_q.data)),
        .step     (step_req),
        .ptr_q    (ptr_q)
    );

    always_comb begin
        wr_strobe = '0;
        if (wr_hit)
            wr_strobe[cmd_q.reg_a] = 1'b1;
        wr_data = cmd_q.data;
        rd_en   = rd_hit;
        rd_data = '0;
        if (rd_hit) begin
            if (cmd_q.reg_a == REG_SELF_ADDR)
                rd_data = DATA_W'(own_addr);
            else if (cmd_q.reg_a == REG_POINTER)
                rd_data = DATA_W'(ptr_q);
            else
                rd_data = rf_rdata;
        end
    end

endmodule

// File: rtl/chain_cmd_decoder_chk.sv
module chain_cmd_decoder_chk
    import chain_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input dec_state_t        state_q,
    input logic [REG_AW-1:0] reg_a,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [ADDR_W-1:0] own_addr,
    input logic [REG_N-1:0]  wr_strobe,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data
);

    a_r12_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));

    a_r11_no_readonly_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe[0] && !wr_strobe[8]);

    a_r10_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    a_r9_master_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_a[REG_AW-1]) |-> own_addr == '0);

    a_r8_local_read_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !reg_a[REG_AW-1]) |-> own_addr == ptr_q);

    a_r2_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe) |=> wr_strobe == '0);

    a_r2_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (|wr_strobe)));

    a_r7_ptr_moves_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> $past(state_q) != ST_IDLE);

endmodule

bind chain_cmd_decoder chain_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .reg_a     (cmd_q.reg_a),
    .ptr_q     (ptr_q),
    .own_addr  (own_addr),
    .wr_strobe (wr_strobe),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
);

// File: tb/chain_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module chain_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  own_addr = 8'h05;
    logic [7:0]  rf_rdata = 8'h5A;
    logic [15:0] wr_strobe;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    logic [15:0] s_strobe;
    logic [7:0]  s_wdata;
    logic        s_rden;
    logic [7:0]  s_rdata;

    always #2 clk = ~clk;

    chain_cmd_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .own_addr  (own_addr),
        .rf_rdata  (rf_rdata),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] cmd);
        @(negedge clk);
        cmd_word  = cmd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        s_strobe  = wr_strobe;
        s_wdata   = wr_data;
        s_rden    = rd_en;
        s_rdata   = rd_data;
    endtask

    task automatic read_ptr(output logic [7:0] val);
        logic [7:0] keep;
        keep = own_addr;
        own_addr = 8'h00;
        issue(16'h8800);
        val = s_rdata;
        own_addr = keep;
    endtask

    task automatic set_ptr(input logic [7:0] v);
        issue({8'h08, v});
    endtask

    task automatic t_reset;
        logic [7:0] p;
        check("R1 strobe", wr_strobe, 16'h0);
        check("R1 rd_en", {15'h0, rd_en}, 16'h0);
        read_ptr(p);
        check("R1 pointer", {8'h0, p}, 16'h0000);
    endtask

    task automatic t_local_write;
        own_addr = 8'h05;
        issue(16'h03A5);
        check("R3 no match", s_strobe, 16'h0);
        set_ptr(8'h05);
        check("R6 no strobe on load", s_strobe, 16'h0);
        issue(16'h03A5);
        check("R3 match", s_strobe, 16'h0008);
        check("R12 data", {8'h0, s_wdata}, 16'h00A5);
    endtask

    task automatic t_global_write;
        logic [7:0] p;
        own_addr = 8'h09;
        issue(16'h2411);
        check("R4 global", s_strobe, 16'h0010);
        issue(16'h6C3C);
        check("R5 high write", s_strobe, 16'h1000);
        read_ptr(p);
        check("R5 no step", {8'h0, p}, 16'h0005);
        issue(16'h1B7E);
        check("R13 reserved bit", s_strobe, 16'h0800);
        check("R6 pointer loaded", {8'h0, p}, 16'h0005);
    endtask

    task automatic t_readonly_write;
        own_addr = 8'h05;
        issue(16'h0077);
        check("R11 reg0 write", s_strobe, 16'h0);
        issue(16'h2077);
        check("R11 reg0 global", s_strobe, 16'h0);
    endtask

    task automatic t_step;
        logic [7:0] p;
        set_ptr(8'hFE);
        own_addr = 8'hFE;
        issue(16'h4122);
        check("R7 pre-step select", s_strobe, 16'h0002);
        issue(16'h4122);
        check("R7 after step", s_strobe, 16'h0);
        read_ptr(p);
        check("R7 wrap", {8'h0, p}, 16'h0000);
    endtask

    task automatic t_local_read;
        logic [7:0] p;
        set_ptr(8'h21);
        own_addr = 8'h21;
        rf_rdata = 8'h5A;
        issue(16'h8300);
        check("R8 match rd_en", {15'h0, s_rden}, 16'h1);
        check("R10 rf data", {8'h0, s_rdata}, 16'h005A);
        own_addr = 8'h22;
        issue(16'hA300);
        check("R8 global bit ignored", {15'h0, s_rden}, 16'h0);
        check("R10 quiet", {8'h0, s_rdata}, 16'h0000);
        own_addr = 8'h21;
        issue(16'h8000);
        check("R10 own address", {8'h0, s_rdata}, 16'h0021);
        issue(16'hC300);
        check("R7 stepping read", {15'h0, s_rden}, 16'h1);
        read_ptr(p);
        check("R7 read step", {8'h0, p}, 16'h0022);
    endtask

    task automatic t_high_read;
        own_addr = 8'h03;
        issue(16'h8D00);
        check("R9 non-master", {15'h0, s_rden}, 16'h0);
        own_addr = 8'h00;
        issue(16'h8D00);
        check("R9 master", {15'h0, s_rden}, 16'h1);
        check("R10 master data", {8'h0, s_rdata}, 16'h005A);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        cmd_word  = 16'h2311;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_word  = 16'h2522;
        check("R2 first", wr_strobe, 16'h0008);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 busy ignored", wr_strobe, 16'h0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_local_write();
        t_global_write();
        t_readonly_write();
        t_step();
        t_local_read();
        t_high_read();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule